// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This unit views each 64-bit operand as an 8x8 matrix of single bits. Byte r of an operand is matrix row r, and bit k inside that byte is column k, counted from the least significant bit. The unit multiplies the first operand by the second under one of three combining rules, or returns the transpose of the first operand. The rule is chosen per request by a 2-bit mode.

- In XOR mode the result is the product over GF(2), with an 8-bit constant XORed into every result row.
- In OR mode each result bit is the OR of the bitwise ANDs.
- In AND mode each result bit is the AND of the bitwise ANDs.

Columns of the second operand come from a transpose network, so every result bit is a reduction of two bytes.

One request is accepted on any cycle where `in_valid` is high. The answer is registered once and appears on the next cycle with `out_valid` set. A two-state controller tracks whether the result register holds a fresh answer:

- ST_IDLE: no fresh answer. It moves to ST_HOLD when `in_valid` is high and stays in ST_IDLE otherwise.
- ST_HOLD: a fresh answer is on `result`. It stays in ST_HOLD on back-to-back requests and returns to ST_IDLE when `in_valid` is low.

Reset forces ST_IDLE.

Top module: `bitmat_unit`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: When `in_valid` is low, `result` keeps its previous value.
- R4: Mode 2'b00 (XOR): result bit i = parity(A.byte[i/8] & Bcol[i%8]) XOR imm[i%8]. Here Bcol[c] bit k = B bit 8k+c, and all bit numbering is LSB0.
- R5: Mode 2'b01 (OR): result bit i is 1 exactly when A.byte[i/8] & Bcol[i%8] is nonzero.
- R6: Mode 2'b10 (AND): result bit i is 1 exactly when A.byte[i/8] & Bcol[i%8] equals 8'hFF.
- R7: Mode 2'b11 (transpose): result bit 8k+j = A bit 8j+k, regardless of B and imm.
- R8: Feeding a transpose result back into a second transpose returns the original operand.
- R9: With B equal to the identity matrix 64'h8040201008040201, XOR mode with imm 0 and OR mode both return A.
- R10: In OR, AND and transpose modes the immediate has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operands sampled this cycle |
| mode | input | 2 | 00 XOR-affine, 01 OR, 10 AND, 11 transpose |
| imm | input | 8 | Per-column constant XORed in XOR mode |
| opa | input | 64 | First matrix, byte r = row r |
| opb | input | 64 | Second matrix, byte r = row r |
| out_valid | output | 1 | Result register holds a fresh answer |
| result | output | 64 | Registered result matrix |

## Verification
A fixed table of operand pairs is run through all four modes. The table includes:

- a matrix that is all ones;
- the identity matrix;
- a single full row;
- checkerboard and stripe patterns.

The all-ones and full-row cases separate the AND rule from the OR rule. The stripe cases expose a swap of row and column indices, because those patterns are not symmetric. Random operand pairs are compared against a loop-based reference. Directed cases cover the identity operand, a double transpose and immediate insensitivity, which together expose a wrong transpose direction or a stray use of the constant.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;
    typedef enum logic [1:0] {
        MD_XOR = 2'b00,
        MD_OR  = 2'b01,
        MD_AND = 2'b10,
        MD_TRN = 2'b11
    } bm_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bm_state_e;
endpackage

// File: rtl/bitmat_transpose.sv
module bitmat_transpose #(
    parameter int DIM = 8,
    localparam int W = DIM * DIM
) (
    input  logic [W-1:0] mat_i,
    output logic [W-1:0] mat_o
);
    // bit k of row j moves to bit j of row k
    for (genvar j = 0; j < DIM; j++) begin : g_row
        for (genvar k = 0; k < DIM; k++) begin : g_col
            assign mat_o[DIM*k + j] = mat_i[DIM*j + k];
        end
    end
endmodule

// File: rtl/bitmat_cell.sv
module bitmat_cell #(
    parameter int DIM = 8
) (
    input  bitmat_pkg::bm_mode_e mode,
    input  logic [DIM-1:0]       row,
    input  logic [DIM-1:0]       col,
    input  logic                 k_bit,
    output logic                 bit_o
);
    import bitmat_pkg::*;

    logic [DIM-1:0] meet;
    assign meet = row & col;

    always_comb begin
        unique case (mode)
            MD_XOR:  bit_o = (^meet) ^ k_bit;
            MD_OR:   bit_o = |meet;
            MD_AND:  bit_o = &meet;
            default: bit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitmat_unit.sv
module bitmat_unit #(
    parameter int DIM = 8,
    localparam int W = DIM * DIM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     mode,
    input  logic [DIM-1:0] imm,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           out_valid,
    output logic [W-1:0]   result
);
    import bitmat_pkg::*;

    bm_mode_e  md;
    bm_state_e state_q, state_d;
    logic [W-1:0] cols_b, trn_a, prod, next_res;

    assign md = bm_mode_e'(mode);

    bitmat_transpose #(.DIM(DIM)) u_colgen (.mat_i(opb), .mat_o(cols_b));
    bitmat_transpose #(.DIM(DIM)) u_trn    (.mat_i(opa), .mat_o(trn_a));

    for (genvar r = 0; r < DIM; r++) begin : g_r
        for (genvar c = 0; c < DIM; c++) begin : g_c
            bitmat_cell #(.DIM(DIM)) u_cell (
                .mode  (md),
                .row   (opa[r*DIM +: DIM]),
                .col   (cols_b[c*DIM +: DIM]),
                .k_bit (imm[c]),
                .bit_o (prod[r*DIM + c])
            );
        end
    end

    assign next_res = (md == MD_TRN) ? trn_a : prod;

    // next-state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= next_res;
    end

    assign out_valid = (state_q == ST_HOLD);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r7_trn_corner: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11) |=> (result[1] == $past(opa[DIM])
                                        && result[DIM] == $past(opa[1])));
endmodule

// File: tb/bitmat_unit_test.sv
module bitmat_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  imm = 8'h00;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    bitmat_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
                     .imm(imm), .opa(opa), .opb(opb), .out_valid(out_valid),
                     .result(result));

    localparam int NV = 8;
    localparam logic [63:0] TA [NV] = '{64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF,
        64'h8040201008040201, 64'hDEADBEEFCAFEF00D, 64'h00000000000000FF,
        64'h5555AAAA3333CCCC, 64'hFFFF0000FFFF0000, 64'h0F0F0F0F0F0F0F0F};
    localparam logic [63:0] TB [NV] = '{64'hFEDCBA9876543210, 64'hFFFFFFFFFFFFFFFF,
        64'h0F0F0F0F0F0F0F0F, 64'h8040201008040201, 64'hFFFFFFFFFFFFFFFF,
        64'h00FF00FF00FF00FF, 64'hFFFFFFFFFFFFFFFF, 64'h123456789ABCDEF0};
    localparam logic [1:0] TM [NV] = '{2'd0, 2'd2, 2'd1, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0};
    localparam logic [7:0] TI [NV] = '{8'h00, 8'h5A, 8'hFF, 8'hFF, 8'h33, 8'h00, 8'hC3, 8'h81};

    function automatic logic [63:0] ref_model(logic [1:0] m, logic [7:0] k,
                                              logic [63:0] a, logic [63:0] b);
        logic [63:0] res = '0;
        for (int i = 0; i < 64; i++) begin
            int r = i / 8;
            int c = i % 8;
            int hits = 0;
            for (int t = 0; t < 8; t++)
                if (a[8*r + t] && b[8*t + c]) hits++;
            case (m)
                2'd0: res[i] = hits[0] ^ k[c];
                2'd1: res[i] = (hits != 0);
                2'd2: res[i] = (hits == 8);
                default: res[i] = a[8*c + r];
            endcase
        end
        return res;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(logic [1:0] m, logic [7:0] k, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        mode = m; imm = k; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] keep, first;
        logic [63:0] lfsr = 64'h9E3779B97F4A7C15;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'b0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", {63'b0, out_valid}, 64'd0);
        check("R1 after reset result", result, 64'd0);

        // table walk: R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            run(TM[v], TI[v], TA[v], TB[v]);
            check($sformatf("R4/R5/R6/R7 table %0d", v), result,
                  ref_model(TM[v], TI[v], TA[v], TB[v]));
            check("R2 valid after request", {63'b0, out_valid}, 64'd1);
        end

        // R2 / R3: valid drops, result held
        keep = result;
        @(negedge clk);
        check("R2 valid drops", {63'b0, out_valid}, 64'd0);
        opa = ~opa; opb = ~opb; mode = 2'd1;
        @(negedge clk);
        check("R3 result held", result, keep);

        // hand-known transpose
        run(2'd3, 8'h00, 64'h00000000000000FF, 64'd0);
        check("R7 full row transposes to column", result, 64'h0101010101010101);

        // random vs reference, every mode
        for (int n = 0; n < 40; n++) begin
            logic [63:0] ra, rb;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            ra = lfsr * 64'h2545F4914F6CDD1D;
            rb = {ra[31:0], ra[63:32]} ^ lfsr;
            run(n[1:0], ra[7:0] ^ rb[15:8], ra, rb);
            case (n % 4)
                0: check("R4 random xor", result, ref_model(2'd0, ra[7:0] ^ rb[15:8], ra, rb));
                1: check("R5 random or", result, ref_model(2'd1, ra[7:0] ^ rb[15:8], ra, rb));
                2: check("R6 random and", result, ref_model(2'd2, ra[7:0] ^ rb[15:8], ra, rb));
                default: check("R7 random transpose", result, ref_model(2'd3, 8'h0, ra, 64'd0));
            endcase
        end

        // R9 identity
        run(2'd0, 8'h00, 64'hDEADBEEFCAFEF00D, 64'h8040201008040201);
        check("R9 identity xor", result, 64'hDEADBEEFCAFEF00D);
        run(2'd1, 8'h00, 64'h0123456789ABCDEF, 64'h8040201008040201);
        check("R9 identity or", result, 64'h0123456789ABCDEF);

        // R8 double transpose
        run(2'd3, 8'h00, 64'h0123456789ABCDEF, 64'd0);
        first = result;
        run(2'd3, 8'hFF, first, 64'hFFFF);
        check("R8 double transpose", result, 64'h0123456789ABCDEF);

        // R10 immediate ignored outside xor
        for (int m = 1; m < 4; m++) begin
            run(m[1:0], 8'h00, 64'h5555AAAA3333CCCC, 64'hDEADBEEFCAFEF00D);
            first = result;
            run(m[1:0], 8'hA7, 64'h5555AAAA3333CCCC, 64'hDEADBEEFCAFEF00D);
            check($sformatf("R10 imm ignored mode %0d", m), result, first);
        end

        // AND with all ones yields all ones, plain xor imm FF inverts
        run(2'd2, 8'h00, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
        check("R6 all ones", result, 64'hFFFFFFFFFFFFFFFF);
        run(2'd0, 8'hFF, 64'h0, 64'hFFFFFFFFFFFFFFFF);
        check("R4 zero matrix with imm", result, 64'hFFFFFFFFFFFFFFFF);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule